// File: doc/BRIEF.md
# Break-Before-Make Latch Output Sequencer

This block turns one request line into the two controls of an 8-bit transparent data latch with a three-state output stage. The controls are a latch-enable, which is high while the latch is transparent, and an active-low output-enable. The block also models the latch and its output stage. The output bus is represented as a data word plus a drive flag.

When the request rises, the latch closes at once and freezes the word on its inputs. The output-enable goes low only after a programmable settle interval. When the request falls, the output-enable goes high at once. The latch reopens only after the same interval. Each control therefore reacts immediately to one edge of the request and late to the other. As a result, the bus is driven only while the latch holds a frozen word. Changing input data can never appear on a driven bus.

The request is first passed through a two-flop synchroniser. A four-state machine then performs the sequencing. Its states are:

- `ST_OPEN`: transparent, outputs off.
- `ST_ARM`: closed, outputs off, counting the turn-on delay.
- `ST_DRIVE`: closed, outputs on.
- `ST_DRAIN`: closed, outputs off, counting the reopen delay.

Its transitions are:

- `T_CLOSE`: `ST_OPEN`→`ST_ARM` when the synchronised request is high.
- `T_ENABLE`: `ST_ARM`→`ST_DRIVE` when the count reaches SETTLE_CYC.
- `T_ABORT`: `ST_ARM`→`ST_DRAIN` when the request drops.
- `T_RELEASE`: `ST_DRIVE`→`ST_DRAIN` when the request drops.
- `T_REARM`: `ST_DRAIN`→`ST_ARM` when the request returns.
- `T_REOPEN`: `ST_DRAIN`→`ST_OPEN` when the count reaches SETTLE_CYC.

In every state, a request change takes priority over an expiring count.

Top module: `bbm_latch_seq`

## Requirements
- R1: While `rst` is high and after its release, the block rests with `latch_en`=1, `oe_n`=1, `bus_drv`=0 and `bus_q`=0.
- R2: `req_in` passes through two synchronising flops. `latch_en` falls on the third rising clock edge after `req_in` rises. The word captured is the `din` value present at that edge.
- R3: `bus_drv` is never 1 while `latch_en` is 1. `bus_q` is 0 whenever `bus_drv` is 0.
- R4: With the request held high, `oe_n` falls exactly SETTLE_CYC (default 4) clock edges after `latch_en` falls. `bus_drv` rises together with it.
- R5: `oe_n` rises on the third rising edge after `req_in` falls. `latch_en` rises exactly SETTLE_CYC edges after that.
- R6: While the latch is closed, the captured word does not change, whatever `din` does. When driving, `bus_q` equals the captured word.
- R7: If the request falls while the turn-on count runs, `bus_drv` stays 0. This holds even when the drop is seen on the edge where the count would expire. The latch reopens SETTLE_CYC edges after the drop is seen.
- R8: If the request returns while the reopen count runs, `latch_en` stays 0 and the old word is kept. This holds even on the expiring edge. `oe_n` falls SETTLE_CYC edges after the return is seen.
- R9: SETTLE_CYC must be at least 1. `latch_en` and `oe_n` never change on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| req_in | input | 1 | Asynchronous request line |
| din | input | 8 | Latch data input |
| latch_en | output | 1 | Latch control, 1 = transparent |
| oe_n | output | 1 | Active-low output enable |
| bus_q | output | 8 | Output bus word, 0 when not driven |
| bus_drv | output | 1 | 1 while the output stage drives `bus_q` |

## Verification
Two events can fall on the same edge. A request change can reach the state machine on exactly the edge where the running settle count expires. This happens as a drop during turn-on (R7) and as a return during turn-off (R8). The bench provokes each by delaying the request change by zero and by one clock after the counting state is entered. The second variant lands on the expiry edge. The request must win in both cases. This is judged by `bus_drv` never rising in the first case. In the second case, `latch_en` must stay low and `bus_q` must still show the old word when the outputs come back on.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_ARM   = 2'd1,
        ST_DRIVE = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_t;

endpackage

// File: rtl/bbm_req_sync.sv
module bbm_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic req_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad_stages
            $error("bbm_req_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], req_async};
        end
    end

    assign req_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bbm_seq_fsm.sv
module bbm_seq_fsm
    import bbm_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_s,
    output logic latch_en,
    output logic oe_n
);

    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    generate
        if (SETTLE_CYC < 1) begin : g_bad_settle
            $error("SETTLE_CYC must be at least 1");
        end
    endgenerate

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OPEN: begin
                if (req_s) begin            // T_CLOSE
                    state_d = ST_ARM;
                    cnt_d   = '0;
                end
            end
            ST_ARM: begin
                if (!req_s) begin           // T_ABORT, wins over expiry
                    state_d = ST_DRAIN;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin   // T_ENABLE
                    state_d = ST_DRIVE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DRIVE: begin
                if (!req_s) begin           // T_RELEASE
                    state_d = ST_DRAIN;
                    cnt_d   = '0;
                end
            end
            ST_DRAIN: begin
                if (req_s) begin            // T_REARM, wins over expiry
                    state_d = ST_ARM;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin   // T_REOPEN
                    state_d = ST_OPEN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_OPEN;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output decode
    always_comb begin
        latch_en = 1'b0;
        oe_n     = 1'b1;
        unique case (state_q)
            ST_OPEN:  begin latch_en = 1'b1; oe_n = 1'b1; end
            ST_ARM:   begin latch_en = 1'b0; oe_n = 1'b1; end
            ST_DRIVE: begin latch_en = 1'b0; oe_n = 1'b0; end
            ST_DRAIN: begin latch_en = 1'b0; oe_n = 1'b1; end
            default:  begin latch_en = 1'b1; oe_n = 1'b1; end
        endcase
    end

    // R3: never enabled while transparent
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(latch_en && !oe_n));

    // R4: outputs switch on only after the latch had already closed
    a_r4_enable_late: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> $past(!latch_en));

    // R5: latch reopens only after outputs were already off
    a_r5_reopen_late: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_en) |-> $past(oe_n));

    // R9: the two controls never move on the same edge
    a_r9_single_change: assert property (@(posedge clk) disable iff (rst)
        $stable(latch_en) || $stable(oe_n));

    // R7: a drop during turn-on keeps the outputs off
    a_r7_abort_off: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARM && !req_s) |=> oe_n);

    // R8: a return during turn-off keeps the latch closed
    a_r8_rearm_closed: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && req_s) |=> (!latch_en && oe_n));

    // R4: the settle count stays in range
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/bbm_latch_stage.sv
module bbm_latch_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_en,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] bus_q,
    output logic              bus_drv
);

    logic [DATA_W-1:0] hold_q;

    // transparent while latch_en is high: follow input each clock
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (latch_en) begin
            hold_q <= din;
        end
    end

    assign bus_drv = !oe_n;
    assign bus_q   = bus_drv ? hold_q : '0;

    // R6: frozen word does not move while the latch stays closed
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && $past(!latch_en)) |-> $stable(hold_q));

    // R3: the stage is never driving with the latch open
    a_r3_stage_safe: assert property (@(posedge clk) disable iff (rst)
        bus_drv |-> !latch_en);

endmodule

// File: rtl/bbm_latch_seq.sv
module bbm_latch_seq #(
    parameter int DATA_W      = 8,
    parameter int SETTLE_CYC  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_in,
    input  logic [DATA_W-1:0] din,
    output logic              latch_en,
    output logic              oe_n,
    output logic [DATA_W-1:0] bus_q,
    output logic              bus_drv
);

    logic req_s;

    bbm_req_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (req_in),
        .req_sync  (req_s)
    );

    bbm_seq_fsm #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_s    (req_s),
        .latch_en (latch_en),
        .oe_n     (oe_n)
    );

    bbm_latch_stage #(
        .DATA_W(DATA_W)
    ) u_stage (
        .clk      (clk),
        .rst      (rst),
        .latch_en (latch_en),
        .oe_n     (oe_n),
        .din      (din),
        .bus_q    (bus_q),
        .bus_drv  (bus_drv)
    );

    // R1: reset leaves the latch transparent and outputs off
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (latch_en && oe_n && !bus_drv));

endmodule

// File: tb/test_bbm_latch_seq.sv
`timescale 1ns/1ps
module test_bbm_latch_seq;

    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_in = 1'b0;
    logic [7:0] din = 8'h00;
    logic       latch_en, oe_n, bus_drv;
    logic [7:0] bus_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bbm_latch_seq #(
        .DATA_W(8), .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)
    ) i_bbm_latch_seq (
        .clk(clk), .rst(rst), .req_in(req_in), .din(din),
        .latch_en(latch_en), .oe_n(oe_n), .bus_q(bus_q), .bus_drv(bus_drv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step_ramp;
        step();
        din = din + 8'd1;
    endtask

    // R3 monitor on every cycle, sampled mid-period
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 drive while transparent", {31'd0, bus_drv && latch_en}, 32'd0);
            if (!bus_drv) chk("R3 idle bus value", {24'd0, bus_q}, 32'd0);
        end
    end

    task automatic t_reset;
        step();
        chk("R1 latch_en in reset", {31'd0, latch_en}, 32'd1);
        chk("R1 oe_n in reset", {31'd0, oe_n}, 32'd1);
        rst = 1'b0;
        step();
        chk("R1 bus_drv after reset", {31'd0, bus_drv}, 32'd0);
        chk("R1 bus_q after reset", {24'd0, bus_q}, 32'd0);
    endtask

    task automatic t_on_off;
        din = 8'h10;
        req_in = 1'b1;
        step_ramp();
        step_ramp();
        chk("R2 latch still open after two edges", {31'd0, latch_en}, 32'd1);
        step_ramp();
        chk("R2 latch closed on third edge", {31'd0, latch_en}, 32'd0);
        for (int k = 0; k < SETTLE - 1; k++) step_ramp();
        chk("R4 outputs still off before settle", {31'd0, oe_n}, 32'd1);
        step_ramp();
        chk("R4 oe_n low after settle", {31'd0, oe_n}, 32'd0);
        chk("R4 bus_drv high", {31'd0, bus_drv}, 32'd1);
        chk("R2 captured word", {24'd0, bus_q}, 32'h12);
        for (int k = 0; k < 5; k++) step_ramp();
        chk("R6 word held under changing din", {24'd0, bus_q}, 32'h12);
        req_in = 1'b0;
        step_ramp();
        step_ramp();
        chk("R5 outputs on before third edge", {31'd0, oe_n}, 32'd0);
        step_ramp();
        chk("R5 oe_n high on third edge", {31'd0, oe_n}, 32'd1);
        for (int k = 0; k < SETTLE - 1; k++) step_ramp();
        chk("R5 latch still closed before settle", {31'd0, latch_en}, 32'd0);
        step_ramp();
        chk("R5 latch reopened after settle", {31'd0, latch_en}, 32'd1);
    endtask

    task automatic t_abort(input int lag);
        din = 8'h40;
        req_in = 1'b1;
        for (int k = 0; k < 3; k++) step_ramp();
        chk("R7 latch closed before abort", {31'd0, latch_en}, 32'd0);
        for (int k = 0; k < lag; k++) step_ramp();
        req_in = 1'b0;
        for (int k = 0; k < 3 + SETTLE - 1; k++) begin
            step_ramp();
            chk("R7 no drive after abort", {31'd0, bus_drv}, 32'd0);
        end
        chk("R7 latch closed until settle", {31'd0, latch_en}, 32'd0);
        step_ramp();
        chk("R7 latch reopened", {31'd0, latch_en}, 32'd1);
    endtask

    task automatic t_reassert(input int lag);
        din = 8'h80;
        req_in = 1'b1;
        for (int k = 0; k < 3 + SETTLE; k++) step_ramp();
        chk("R8 driving before drop", {31'd0, bus_drv}, 32'd1);
        chk("R8 captured word", {24'd0, bus_q}, 32'h82);
        req_in = 1'b0;
        for (int k = 0; k < 3; k++) step_ramp();
        chk("R8 outputs off after drop", {31'd0, oe_n}, 32'd1);
        for (int k = 0; k < lag; k++) step_ramp();
        req_in = 1'b1;
        for (int k = 0; k < 3 + SETTLE - 1; k++) begin
            step_ramp();
            chk("R8 latch stays closed", {31'd0, latch_en}, 32'd0);
        end
        chk("R8 outputs off during new turn-on", {31'd0, oe_n}, 32'd1);
        step_ramp();
        chk("R8 outputs back on", {31'd0, oe_n}, 32'd0);
        chk("R8 old word kept", {24'd0, bus_q}, 32'h82);
        req_in = 1'b0;
        for (int k = 0; k < 3 + SETTLE; k++) step_ramp();
        chk("R5 latch open at end", {31'd0, latch_en}, 32'd1);
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_on_off();
        t_abort(0);
        t_abort(1);   // drop seen on the expiry edge
        t_reassert(0);
        t_reassert(1); // return seen on the expiry edge
        step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule